// File: doc/BRIEF.md
# Clock-Loss Detector with Timeout

This block watches a single monitored clock from a free-running reference clock and reports when that clock has stopped. It brings the monitored level into the reference domain and compares successive samples. Every change reloads a down-counter. If the counter runs out before another change arrives, a stall flag is raised. Because either kind of change reloads the counter, a clock frozen high is caught in the same way as one frozen low.

One select input picks one of two timeout lengths, a long one and a short one, in an eight-to-one ratio. With a 100 MHz reference the defaults give 640 ns and 80 ns. The flag drops as soon as a new transition is detected. It does not wait for a qualification period. Out of reset the flag is set, and it stays set until the monitored clock has shown activity. The flag can therefore drive the select of a clock switch directly: the switch falls back to a backup clock whenever the main one is silent or has not yet been seen. When the enable is low, the flag pin is released to high impedance.

A running clock whose half period is longer than the selected timeout will make the flag pulse between its edges. This behaviour is accepted.

Top module: `clk_stall_watch`

## Requirements
- R1: After reset the flag reads 1 and stays 1 while the monitored clock makes no transition, whatever level the monitored clock holds during and after reset.
- R2: With the select at 0, the count is LONG_COUNT (default 64). A change on the monitored clock made between reference edges reloads this count. If no further change follows, the flag is still 0 after LONG_COUNT+3 reference rising edges and is 1 after LONG_COUNT+4.
- R3: With the select at 1, the count is SHORT_COUNT (default 8). The same timing rule applies: the flag is 0 after SHORT_COUNT+3 edges and 1 after SHORT_COUNT+4.
- R4: A monitored clock that stops low and one that stops high are both flagged, with the same timing.
- R5: While the flag is set, a change on the monitored clock clears it. The flag still reads 1 after one reference edge and reads 0 after the second edge (synchronizer latency only).
- R6: A monitored clock that changes level at least once every four reference cycles keeps the flag at 0.
- R7: A monitored clock whose level is held longer than the short timeout sets the flag between its transitions, and each transition clears it again.
- R8: When the enable input is 0, the flag pin is not driven. When the enable is 1, the pin shows the flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| monClk | input | 1 | Monitored clock, asynchronous to refClk |
| shortSel | input | 1 | Timeout select: 1 = short count, 0 = long count |
| flagEn | input | 1 | Output enable for the flag; 0 releases the pin to high impedance |
| stallFlag | output | 1 | 1 when the monitored clock is considered stopped |

## Verification
The bench changes the monitored clock only on falling reference edges and samples the flag on falling edges. This puts every result a whole number of rising edges after its stimulus:
- A change passes the two synchronizer stages in two edges, and from that point the flag is already low.
- The counter is loaded on the third edge.
- The flag sets on edge count+4.

Each timeout check samples exactly one cycle before and one cycle after that set point. This pins the latency exactly instead of accepting a window. The clear check samples after one edge and after two edges.

// File: rtl/clk_stall_watch_pkg.sv
package clk_stall_watch_pkg;

  // strobes issued by the control to the counter datapath
  typedef struct packed {
    logic load;  // reload the timeout counter
    logic dec;   // count one reference cycle down
  } ctrlStrobe_t;

endpackage

// File: rtl/stall_watch_dp.sv
module stall_watch_dp
  import clk_stall_watch_pkg::*;
#(
  parameter int LONG_COUNT  = 64,
  parameter int SHORT_COUNT = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(LONG_COUNT + 1)
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             monClk,
  input  logic             shortSel,
  input  ctrlStrobe_t      strobes,
  output logic             edgeSeen,
  output logic             cntZero,
  output logic [CNT_W-1:0] cntVal
);

  localparam int ARM_CYCLES = SYNC_STAGES + 1;
  localparam int ARM_W      = $clog2(ARM_CYCLES + 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_COUNT);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_COUNT);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLvl;
  logic [ARM_W-1:0]       armCnt;
  logic                   armed;
  logic [CNT_W-1:0]       cntQ;

  // level synchronizer: stage 0 samples the asynchronous input
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= monClk;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= syncQ[SYNC_STAGES-1];
  end

  // edge compare is meaningless until the chain holds real samples
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                           armCnt <= '0;
    else if (armCnt != ARM_W'(ARM_CYCLES)) armCnt <= armCnt + 1'b1;
  end

  assign armed    = (armCnt == ARM_W'(ARM_CYCLES));
  assign edgeSeen = armed && (syncQ[SYNC_STAGES-1] != prevLvl);

  // timeout counter
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (strobes.load) cntQ <= shortSel ? SHORT_LOAD : LONG_LOAD;
    else if (strobes.dec)  cntQ <= cntQ - 1'b1;
  end

  assign cntZero = (cntQ == '0);
  assign cntVal  = cntQ;

endmodule

// File: rtl/stall_watch_ctl.sv
module stall_watch_ctl
  import clk_stall_watch_pkg::*;
(
  input  logic        refClk,
  input  logic        rstN,
  input  logic        edgeSeen,
  input  logic        cntZero,
  output ctrlStrobe_t strobes,
  output logic        stalledQ,
  output logic        flagRaw
);

  always_comb begin
    strobes      = '0;
    strobes.load = edgeSeen;
    strobes.dec  = !edgeSeen && !cntZero;
  end

  // flag register: set out of reset, set on expiry, cleared by activity
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)         stalledQ <= 1'b1;
    else if (edgeSeen) stalledQ <= 1'b0;
    else if (cntZero)  stalledQ <= 1'b1;
  end

  // a detected transition masks the flag in the same cycle
  assign flagRaw = stalledQ && !edgeSeen;

endmodule

// File: rtl/clk_stall_watch.sv
module clk_stall_watch
  import clk_stall_watch_pkg::*;
#(
  parameter int LONG_COUNT  = 64,
  parameter int SHORT_COUNT = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic monClk,
  input  logic shortSel,
  input  logic flagEn,
  output logic stallFlag
);

  localparam int CNT_W = $clog2(LONG_COUNT + 1);

  ctrlStrobe_t      strobes;
  logic             edgeSeen;
  logic             cntZero;
  logic [CNT_W-1:0] cntVal;
  logic             stalledQ;
  logic             flagRaw;

  stall_watch_dp #(
    .LONG_COUNT (LONG_COUNT),
    .SHORT_COUNT(SHORT_COUNT),
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) u_dp (
    .refClk  (refClk),
    .rstN    (rstN),
    .monClk  (monClk),
    .shortSel(shortSel),
    .strobes (strobes),
    .edgeSeen(edgeSeen),
    .cntZero (cntZero),
    .cntVal  (cntVal)
  );

  stall_watch_ctl u_ctl (
    .refClk  (refClk),
    .rstN    (rstN),
    .edgeSeen(edgeSeen),
    .cntZero (cntZero),
    .strobes (strobes),
    .stalledQ(stalledQ),
    .flagRaw (flagRaw)
  );

  assign stallFlag = flagEn ? flagRaw : 1'bz;

endmodule

// File: rtl/clk_stall_watch_chk.sv
module clk_stall_watch_chk #(
  parameter int LONG_COUNT  = 64,
  parameter int SHORT_COUNT = 8,
  parameter int CNT_W       = 7
) (
  input logic             refClk,
  input logic             rstN,
  input logic             shortSel,
  input logic             edgeSeen,
  input logic             cntZero,
  input logic [CNT_W-1:0] cntVal,
  input logic             stalledQ
);

  // flag is set coming out of reset
  assert_reset_flag_R1: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(rstN) |-> stalledQ);

  // the flag may only rise once the counter has run out
  assert_rise_after_expiry_R2: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(stalledQ) |-> $past(cntZero));

  // short select reloads the short count
  assert_short_reload_R3: assert property (@(posedge refClk) disable iff (!rstN)
    (edgeSeen && shortSel) |=> (cntVal == CNT_W'(SHORT_COUNT)));

  // long select reloads the long count; either stop level uses this path
  assert_long_reload_R4: assert property (@(posedge refClk) disable iff (!rstN)
    (edgeSeen && !shortSel) |=> (cntVal == CNT_W'(LONG_COUNT)));

  // a detected transition leaves the flag register clear
  assert_edge_clears_R5: assert property (@(posedge refClk) disable iff (!rstN)
    edgeSeen |=> !stalledQ);

  // while time remains the flag cannot be set
  assert_running_clear_R6: assert property (@(posedge refClk) disable iff (!rstN)
    !cntZero |-> !stalledQ);

endmodule

bind clk_stall_watch clk_stall_watch_chk #(
  .LONG_COUNT (LONG_COUNT),
  .SHORT_COUNT(SHORT_COUNT),
  .CNT_W      (CNT_W)
) u_chk (
  .refClk  (refClk),
  .rstN    (rstN),
  .shortSel(shortSel),
  .edgeSeen(edgeSeen),
  .cntZero (cntZero),
  .cntVal  (cntVal),
  .stalledQ(stalledQ)
);

// File: tb/clk_stall_watch_tb.sv
`timescale 1ns/1ps
module clk_stall_watch_tb;

  localparam int LONG_N  = 64;
  localparam int SHORT_N = 8;

  logic refClk = 1'b0;
  logic rstN   = 1'b0;
  logic monClk = 1'b0;
  logic shortSel = 1'b0;
  logic flagEn = 1'b1;
  wire  stallFlag;

  int errors = 0;
  int checks = 0;

  always #5 refClk = ~refClk;

  clk_stall_watch #(
    .LONG_COUNT (LONG_N),
    .SHORT_COUNT(SHORT_N),
    .SYNC_STAGES(2)
  ) u_dut (
    .refClk   (refClk),
    .rstN     (rstN),
    .monClk   (monClk),
    .shortSel (shortSel),
    .flagEn   (flagEn),
    .stallFlag(stallFlag)
  );

  task automatic step(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic expectFlag(input logic exp, input string req, input string what);
    checks++;
    if (stallFlag !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, stallFlag, exp);
    end
  endtask

  // R1: reset with the monitored clock held high
  task automatic testReset();
    rstN = 1'b0; monClk = 1'b1; shortSel = 1'b0; flagEn = 1'b1;
    step(3);
    rstN = 1'b1;
    step(1);
    expectFlag(1'b1, "R1", "flag just after reset");
    step(20);
    expectFlag(1'b1, "R1", "flag with no transition after reset");
  endtask

  // R2, R4 (stop low), R5
  task automatic testLongLow();
    shortSel = 1'b0;
    monClk = 1'b0;
    step(1);
    expectFlag(1'b1, "R5", "one edge after change");
    step(1);
    expectFlag(1'b0, "R5", "two edges after change");
    step(LONG_N + 1);
    expectFlag(1'b0, "R2", "long timeout minus one");
    step(1);
    expectFlag(1'b1, "R4", "stuck low flagged at long timeout");
  endtask

  // R3, R4 (stop high), R5
  task automatic testShortHigh();
    shortSel = 1'b1;
    monClk = 1'b1;
    step(1);
    expectFlag(1'b1, "R5", "one edge after rising change");
    step(1);
    expectFlag(1'b0, "R5", "two edges after rising change");
    step(SHORT_N + 1);
    expectFlag(1'b0, "R3", "short timeout minus one");
    step(1);
    expectFlag(1'b1, "R4", "stuck high flagged at short timeout");
  endtask

  // R6: fast activity keeps the flag low
  task automatic testActive();
    shortSel = 1'b1;
    for (int i = 0; i < 10; i++) begin
      monClk = ~monClk;
      step(4);
      expectFlag(1'b0, "R6", "active clock");
    end
  endtask

  // R7: slow clock pulses the flag between transitions
  task automatic testSlow();
    shortSel = 1'b1;
    step(SHORT_N + 6);
    for (int i = 0; i < 3; i++) begin
      monClk = ~monClk;
      step(3);
      expectFlag(1'b0, "R7", "slow clock right after transition");
      step(SHORT_N + 3);
      expectFlag(1'b1, "R7", "slow clock between transitions");
    end
  endtask

  // R8: output enable
  task automatic testEnable();
    flagEn = 1'b0;
    step(1);
    checks++;
    if (stallFlag === 1'b1) begin
      errors++;
      $display("FAIL R8 disabled pin driven: actual=%b expected=z", stallFlag);
    end
    flagEn = 1'b1;
    step(1);
    expectFlag(1'b1, "R8", "re-enabled pin");
  endtask

  initial begin
    testReset();
    testLongLow();
    testShortHigh();
    testActive();
    testSlow();
    testEnable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule